// File: doc/BRIEF.md
# Serial Shift-and-Latch Output Register

This block turns a serial bit stream into a parallel word. Each rising clock edge pushes one bit from the serial input into an 8-stage chain. A storage register sits between the chain and the parallel outputs. While the strobe input is high, the storage register follows the chain. While the strobe is low, it holds its last word, so the chain can be reloaded without disturbing the outputs.

The parallel outputs come with a per-bit drive-enable vector. The enclosing level uses it to build three-state pads or a bus mux, so the core has no tri-state nets. The output-enable input controls only this vector.

Two serial outputs allow several blocks to be chained:
- One output presents the last chain stage directly. It changes on the rising edge.
- The other output re-times the last stage on the falling edge. A downstream block that samples it on the next rising edge therefore has half a clock period of hold margin.

A synchronous active-low reset clears the chain, the storage register and the falling-edge output.

Top module: `shift_latch_out_reg`

## Requirements
- R1: On every rising clock edge that is not in reset, stage 0 of the chain takes `ser_in` and stage n takes the old stage n-1, for n from 1 to WIDTH-1.
- R2: When `strobe` is 1 at a rising edge, `par_q` after that edge equals the chain contents after that edge. With `strobe` held at 1 across several edges, `par_q` tracks the chain on every edge. Bit i of `par_q` is chain stage i, so the first of eight bits shifted in appears on bit 7.
- R3: When `strobe` is 0 at a rising edge, `par_q` keeps its value, although the chain still shifts.
- R4: `par_oe` is all ones while `out_en` is 1 and all zeros while `out_en` is 0. A 1 means the matching `par_q` bit is driven; a 0 means it is high impedance.
- R5: `ser_rise` equals the last chain stage (WIDTH-1) and changes only after a rising edge.
- R6: `ser_fall` captures the last chain stage on each falling edge and holds it until the next falling edge.
- R7: Both serial outputs behave the same whatever the values of `out_en` and `strobe`.
- R8: While `rst_n` is 0 at a rising edge, the chain and the storage register clear to zero. While `rst_n` is 0 at a falling edge, `ser_fall` clears to zero.
- R9: When one block's `ser_fall` drives a second block's `ser_in`, the pair acts as a 2*WIDTH-stage chain. After 16 bits are shifted in most-significant first, with `strobe` high on the last edge, the second block holds the upper byte and the first block holds the lower byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock; the chain shifts on the rising edge and `ser_fall` updates on the falling edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_in | input | 1 | Serial data into stage 0 |
| strobe | input | 1 | 1: storage register follows the chain; 0: storage register holds |
| out_en | input | 1 | 1: parallel outputs driven; 0: parallel outputs high impedance |
| par_q | output | WIDTH | Storage register contents |
| par_oe | output | WIDTH | Per-bit drive enable for `par_q` |
| ser_rise | output | 1 | Last chain stage, updated on the rising edge |
| ser_fall | output | 1 | Last chain stage, re-timed to the falling edge |

## Verification
All 256 byte values are shifted in most-significant bit first, with the strobe raised only on the eighth edge:
- Steps with the strobe low show that the outputs hold while the chain moves.
- The final compare against the byte value itself catches a reversed bit order or an off-by-one shift.

The output enable toggles in a pattern that is not tied to the data, which separates the drive-enable vector from the serial outputs. A run with the strobe held high tells a synchronous follower apart from a one-shot capture.

Several 16-bit words pass through two blocks chained by the falling-edge output:
- Words with a single bit set at either end, all ones, and mixed words show that no bit is lost or duplicated at the block boundary.
- Reset applied in mid-stream shows that every stage and the falling-edge output clear.

// File: rtl/shift_latch_out_reg.sv
module shift_latch_out_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_in,
  input  logic             strobe,
  input  logic             out_en,
  output logic [WIDTH-1:0] par_q,
  output logic [WIDTH-1:0] par_oe,
  output logic             ser_rise,
  output logic             ser_fall
);

  localparam int TOP = WIDTH - 1;

  logic [WIDTH-1:0] chain_q;
  logic [WIDTH-1:0] chain_d;
  logic [WIDTH-1:0] store_q;

  assign chain_d = {chain_q[TOP-1:0], ser_in};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain_q <= '0;
      store_q <= '0;
    end else begin
      chain_q <= chain_d;
      if (strobe) store_q <= chain_d;
    end
  end

  always_ff @(negedge clk) begin
    if (!rst_n) ser_fall <= 1'b0;
    else        ser_fall <= chain_q[TOP];
  end

  assign ser_rise = chain_q[TOP];
  assign par_q    = store_q;
  assign par_oe   = {WIDTH{out_en}};

  p_shift_advance_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ser_rise == $past(chain_q[TOP-1]));

  p_strobe_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> par_q == {$past(chain_q[TOP-1:0]), $past(ser_in)});

  p_strobe_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(par_q));

  p_fall_capture_r6: assert property (@(negedge clk) disable iff (!rst_n)
    1'b1 |=> ser_fall == $past(ser_rise));

  p_reset_clear_r8: assert property (@(posedge clk)
    !rst_n |=> (par_q == '0 && ser_rise == 1'b0));

endmodule

// File: tb/shift_latch_out_reg_tb.sv
module shift_latch_out_reg_tb_top;

  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n, ser_in, strobe, out_en;
  logic [W-1:0] par_q, par_oe, b_par_q, b_par_oe;
  logic ser_rise, ser_fall, b_ser_rise, b_ser_fall;

  int n_checks = 0;
  int n_errors = 0;

  logic [W-1:0] m_shift, m_store;

  always #10 clk = ~clk;

  shift_latch_out_reg #(.WIDTH(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .strobe(strobe), .out_en(out_en),
    .par_q(par_q), .par_oe(par_oe), .ser_rise(ser_rise), .ser_fall(ser_fall));

  shift_latch_out_reg #(.WIDTH(W)) dut_b (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_fall), .strobe(strobe), .out_en(out_en),
    .par_q(b_par_q), .par_oe(b_par_oe), .ser_rise(b_ser_rise), .ser_fall(b_ser_fall));

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic d, input logic s, input logic oe);
    ser_in = d; strobe = s; out_en = oe;
    @(posedge clk);
    m_shift = {m_shift[W-2:0], d};
    if (s) m_store = m_shift;
    #12;
    check(16'(par_q), 16'(m_store), s ? "R2 par_q follows" : "R3 par_q holds");
    check(16'(par_oe), 16'(oe ? {W{1'b1}} : {W{1'b0}}), "R4 par_oe");
    check(16'(ser_rise), 16'(m_shift[W-1]), (oe && s) ? "R1 R5 ser_rise" : "R7 ser_rise");
    check(16'(ser_fall), 16'(m_shift[W-1]), "R6 ser_fall");
  endtask

  task automatic do_reset();
    rst_n = 1'b0; strobe = 1'b0;
    repeat (3) @(posedge clk);
    #12;
    m_shift = '0; m_store = '0;
    check(16'(par_q), 16'h0, "R8 par_q reset");
    check(16'(ser_rise), 16'h0, "R8 ser_rise reset");
    check(16'(ser_fall), 16'h0, "R8 ser_fall reset");
    check(16'(b_par_q), 16'h0, "R8 second block reset");
    rst_n = 1'b1;
  endtask

  initial begin
    #(20 * 200000);
    n_errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    logic [15:0] words [6];
    rst_n = 1'b0; ser_in = 1'b0; strobe = 1'b0; out_en = 1'b0;
    m_shift = '0; m_store = '0;
    do_reset();

    for (int b = 0; b < 256; b++) begin
      for (int i = W - 1; i >= 0; i--)
        step(b[i], i == 0, b[0] ^ i[0]);
      check(16'(par_q), 16'(b), "R2 byte after strobe");
    end

    for (int k = 0; k < 12; k++)
      step(((k * 5) % 3) == 0, 1'b1, 1'b1);

    for (int k = 0; k < 10; k++)
      step(k[0], 1'b0, 1'b0);

    do_reset();
    step(1'b1, 1'b1, 1'b1);
    step(1'b1, 1'b1, 1'b1);
    do_reset();

    words[0] = 16'hA5C3; words[1] = 16'h0001; words[2] = 16'h8000;
    words[3] = 16'hFFFF; words[4] = 16'h1234; words[5] = 16'h0F0F;
    for (int w = 0; w < 6; w++) begin
      for (int i = 15; i >= 0; i--)
        step(words[w][i], i == 0, 1'b1);
      check(16'(par_q), 16'(words[w][7:0]), "R9 first block low byte");
      check(16'(b_par_q), 16'(words[w][15:8]), "R9 second block high byte");
    end

    $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule